// File: doc/BRIEF.md
# Condition Flag Value Predictor

This block guesses the four-bit condition result (negative, zero, carry, overflow) of a flag-setting instruction when that instruction is renamed. With a guess in hand, later conditionally executed instructions that write the same architectural register can be given one physical register. Without a guess, rename has to wait for the real flags. The predictor keeps a direct-mapped table addressed by instruction address. Each entry remembers the two latest distinct flag values that the instruction produced. A two-bit selector counter picks one of them, and a confidence counter decides whether the guess is trustworthy enough to use.

The rename stage presents an address on the lookup port. In the same cycle it gets back a hit indication, the predicted flags, and either a use signal or a stall request. The stall request is raised when the entry is missing or when its confidence is below the run-time threshold. Once the instruction executes, the resolve port delivers the real flags, together with whether a prediction was used and what that prediction was. The table learns from this, and a one-cycle mispredict pulse follows whenever a used prediction was wrong.

Top module: `flag_pred`

## Requirements
- R1: After a synchronous reset every entry is invalid, so any lookup reports lk_hit=0 and lk_stall=1, and mispred is 0.
- R2: The entry index is PC[7:2] and the tag is PC[31:8]. A lookup whose index matches a valid entry but whose tag differs is a miss: lk_hit=0 and lk_stall=1.
- R3: A resolve that misses writes the entry with both stored values equal to the actual flags, selector 0 and confidence 0. A later lookup then hits and predicts those flags.
- R4: A prediction is issued (lk_use=1) only on a hit whose confidence counter is greater than or equal to the thresh input.
- R5: A resolve whose flags equal a stored value raises confidence by one, saturating at 3. It moves the selector one step toward that value, with the counter saturating at 0 and 3. If both stored values are equal, the selector is left alone.
- R6: Selector values 0 and 1 choose value0, and values 2 and 3 choose value1. A resolve whose flags match neither stored value overwrites the older of the two and sets the selector to 1 (slot 0) or 2 (slot 1) so that it points at the new value. It also clears confidence.
- R7: mispred is 1 for exactly the cycle after a resolve with rs_used=1 and rs_pred different from rs_flags. Otherwise it is 0.
- R8: When a lookup and a resolve address the same entry in the same cycle, the lookup sees the entry as it was before that resolve.
- R9: lk_stall equals lk_valid and not lk_use. With lk_valid=0, lk_hit, lk_use and lk_stall are all 0.
- R10: With rs_valid=0, the resolve inputs leave the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| thresh | input | CONF_W | Minimum confidence needed to issue a prediction |
| lk_valid | input | 1 | Lookup request from rename |
| lk_pc | input | PC_W | Address of the flag-setting instruction being renamed |
| lk_hit | output | 1 | Valid entry with matching tag |
| lk_use | output | 1 | Prediction issued |
| lk_stall | output | 1 | Rename must wait for the real flags |
| lk_flags | output | 4 | Predicted flags |
| rs_valid | input | 1 | Resolve update valid |
| rs_pc | input | PC_W | Address of the resolving instruction |
| rs_flags | input | 4 | Actual flags |
| rs_used | input | 1 | A prediction was used for this instruction |
| rs_pred | input | 4 | The prediction that was used |
| mispred | output | 1 | One-cycle pulse for a wrong used prediction |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 64-entry table and two-bit confidence. Random addresses are drawn from a small pool. That pool shares a few indices under different tags, so aliasing misses, reallocation, repeated matches that saturate confidence and value replacements all happen often. The threshold is drawn over its whole range of 0 to 3, so the boundary where confidence equals the threshold is exercised many times.

// File: rtl/flag_pred.sv
module flag_pred #(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 6,
  parameter int CONF_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CONF_W-1:0] thresh,
  input  logic              lk_valid,
  input  logic [PC_W-1:0]   lk_pc,
  output logic              lk_hit,
  output logic              lk_use,
  output logic              lk_stall,
  output logic [3:0]        lk_flags,
  input  logic              rs_valid,
  input  logic [PC_W-1:0]   rs_pc,
  input  logic [3:0]        rs_flags,
  input  logic              rs_used,
  input  logic [3:0]        rs_pred,
  output logic              mispred
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int TAG_W = PC_W - IDX_W - 2;
  localparam logic [CONF_W-1:0] CMAX = '1;

  logic              vld [DEPTH];
  logic [TAG_W-1:0]  tag [DEPTH];
  logic [3:0]        va  [DEPTH];
  logic [3:0]        vb  [DEPTH];
  logic [1:0]        sel [DEPTH];
  logic [CONF_W-1:0] conf[DEPTH];
  logic              nb  [DEPTH];

  logic [IDX_W-1:0] li, ri;
  logic [TAG_W-1:0] lt, rt;
  logic rs_hit, ma, mb;

  assign li = lk_pc[IDX_W+1:2];
  assign lt = lk_pc[PC_W-1:IDX_W+2];
  assign ri = rs_pc[IDX_W+1:2];
  assign rt = rs_pc[PC_W-1:IDX_W+2];

  assign lk_hit   = lk_valid && vld[li] && (tag[li] == lt);
  assign lk_flags = sel[li][1] ? vb[li] : va[li];
  assign lk_use   = lk_hit && (conf[li] >= thresh);
  assign lk_stall = lk_valid && !lk_use;

  assign rs_hit = vld[ri] && (tag[ri] == rt);
  assign ma     = (rs_flags == va[ri]);
  assign mb     = (rs_flags == vb[ri]);

  always_ff @(posedge clk) begin
    if (rst) begin
      mispred <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        vld[i]  <= 1'b0;
        tag[i]  <= '0;
        va[i]   <= '0;
        vb[i]   <= '0;
        sel[i]  <= '0;
        conf[i] <= '0;
        nb[i]   <= 1'b0;
      end
    end else begin
      mispred <= rs_valid && rs_used && (rs_pred != rs_flags);
      if (rs_valid) begin
        if (!rs_hit) begin
          vld[ri]  <= 1'b1;
          tag[ri]  <= rt;
          va[ri]   <= rs_flags;
          vb[ri]   <= rs_flags;
          sel[ri]  <= 2'd0;
          conf[ri] <= '0;
          nb[ri]   <= 1'b0;
        end else if (ma || mb) begin
          if (conf[ri] != CMAX) conf[ri] <= conf[ri] + 1'b1;
          if (ma && !mb) begin
            if (sel[ri] != 2'd0) sel[ri] <= sel[ri] - 2'd1;
            nb[ri] <= 1'b0;
          end else if (mb && !ma) begin
            if (sel[ri] != 2'd3) sel[ri] <= sel[ri] + 2'd1;
            nb[ri] <= 1'b1;
          end
        end else begin
          conf[ri] <= '0;
          if (nb[ri]) begin
            va[ri]  <= rs_flags;
            sel[ri] <= 2'd1;
            nb[ri]  <= 1'b0;
          end else begin
            vb[ri]  <= rs_flags;
            sel[ri] <= 2'd2;
            nb[ri]  <= 1'b1;
          end
        end
      end
    end
  end

  assert_alloc_R3: assert property (@(posedge clk) disable iff (rst)
    rs_valid && !rs_hit |=> vld[$past(ri)] && conf[$past(ri)] == '0 &&
      va[$past(ri)] == $past(rs_flags) && vb[$past(ri)] == $past(rs_flags));

  assert_conf_sat_R5: assert property (@(posedge clk) disable iff (rst)
    rs_valid && rs_hit && (ma || mb) && conf[ri] == CMAX |=> conf[$past(ri)] == CMAX);

  assert_replace_R6: assert property (@(posedge clk) disable iff (rst)
    rs_valid && rs_hit && !ma && !mb |=> conf[$past(ri)] == '0 &&
      (sel[$past(ri)][1] ? vb[$past(ri)] : va[$past(ri)]) == $past(rs_flags));

  assert_mispred_src_R7: assert property (@(posedge clk) disable iff (rst)
    mispred |-> $past(rs_valid && rs_used));

  assert_use_or_stall_R9: assert property (@(posedge clk) disable iff (rst)
    lk_valid |-> $onehot({lk_use, lk_stall}));
endmodule

// File: tb/flag_pred_tb.sv
`timescale 1ns/1ps
module flag_pred_tb;
  logic clk = 0, rst = 1;
  logic [1:0] thresh = 0;
  logic lk_valid = 0, rs_valid = 0, rs_used = 0;
  logic [31:0] lk_pc = 0, rs_pc = 0;
  logic [3:0] rs_flags = 0, rs_pred = 0;
  logic lk_hit, lk_use, lk_stall, mispred;
  logic [3:0] lk_flags;

  int checks = 0, errors = 0;
  bit done = 0;
  bit exp_mis = 0;

  bit         m_v [64];
  logic [23:0] m_t[64];
  logic [3:0] m_a [64], m_b[64];
  int         m_s [64], m_c[64];
  bit         m_n [64];

  always #10 clk = ~clk;

  flag_pred u_dut (.clk(clk), .rst(rst), .thresh(thresh), .lk_valid(lk_valid), .lk_pc(lk_pc),
    .lk_hit(lk_hit), .lk_use(lk_use), .lk_stall(lk_stall), .lk_flags(lk_flags),
    .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_flags(rs_flags), .rs_used(rs_used),
    .rs_pred(rs_pred), .mispred(mispred));

  task automatic chk(string r, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  function automatic logic [3:0] m_pred(int i);
    return (m_s[i] >= 2) ? m_b[i] : m_a[i];
  endfunction

  task automatic step(bit lv, logic [31:0] lp, bit rv, logic [31:0] rp, logic [3:0] rf,
                      bit ru, logic [3:0] rpd, logic [1:0] th, string r);
    int i;
    bit eh, eu;
    @(negedge clk);
    lk_valid = lv; lk_pc = lp; rs_valid = rv; rs_pc = rp; rs_flags = rf;
    rs_used = ru; rs_pred = rpd; thresh = th;
    #1;
    i  = int'(lp[7:2]);
    eh = lv && m_v[i] && (m_t[i] == lp[31:8]);
    eu = eh && (m_c[i] >= int'(th));
    chk(r, "lk_hit", 32'(lk_hit), 32'(eh));
    chk(r, "lk_use", 32'(lk_use), 32'(eu));
    chk(r, "lk_stall", 32'(lk_stall), 32'(lv && !eu));
    if (eh) chk(r, "lk_flags", 32'(lk_flags), 32'(m_pred(i)));
    chk("R7", "mispred", 32'(mispred), 32'(exp_mis));
    @(posedge clk);
    exp_mis = rv && ru && (rpd != rf);
    if (rv) begin
      int j = int'(rp[7:2]);
      bit h = m_v[j] && (m_t[j] == rp[31:8]);
      bit a = (rf == m_a[j]), b = (rf == m_b[j]);
      if (!h) begin
        m_v[j] = 1; m_t[j] = rp[31:8]; m_a[j] = rf; m_b[j] = rf;
        m_s[j] = 0; m_c[j] = 0; m_n[j] = 0;
      end else if (a || b) begin
        if (m_c[j] < 3) m_c[j]++;
        if (a && !b) begin if (m_s[j] > 0) m_s[j]--; m_n[j] = 0; end
        else if (b && !a) begin if (m_s[j] < 3) m_s[j]++; m_n[j] = 1; end
      end else begin
        m_c[j] = 0;
        if (m_n[j]) begin m_a[j] = rf; m_s[j] = 1; m_n[j] = 0; end
        else begin m_b[j] = rf; m_s[j] = 2; m_n[j] = 1; end
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  localparam logic [31:0] A = 32'h0000_0100;
  localparam logic [31:0] B = 32'h0000_0200;
  localparam logic [31:0] C = 32'h0000_0104;

  initial begin
    for (int i = 0; i < 64; i++) begin
      m_v[i] = 0; m_t[i] = 0; m_a[i] = 0; m_b[i] = 0; m_s[i] = 0; m_c[i] = 0; m_n[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    step(1, A, 0, 0, 0, 0, 0, 0, "R1");
    step(1, C, 0, 0, 0, 0, 0, 0, "R1");
    step(0, A, 1, A, 4'h4, 0, 0, 0, "R3");
    step(1, A, 0, 0, 0, 0, 0, 0, "R3");
    step(1, A, 0, 0, 0, 0, 0, 1, "R4");
    step(1, B, 0, 0, 0, 0, 0, 0, "R2");
    step(1, A, 1, A, 4'h4, 0, 0, 1, "R8");
    step(1, A, 0, 0, 0, 0, 0, 1, "R4");
    step(1, A, 0, 0, 0, 0, 0, 2, "R4");
    step(0, 0, 1, A, 4'h4, 0, 0, 0, "R5");
    step(0, 0, 1, A, 4'h4, 0, 0, 0, "R5");
    step(0, 0, 1, A, 4'h4, 0, 0, 0, "R5");
    step(1, A, 0, 0, 0, 0, 0, 3, "R5");
    step(0, 0, 1, A, 4'h9, 1, 4'h4, 0, "R6");
    step(1, A, 0, 0, 0, 0, 0, 0, "R6");
    step(1, A, 0, 0, 0, 0, 0, 1, "R6");
    step(0, 0, 1, A, 4'h4, 1, 4'h4, 0, "R5");
    step(1, A, 0, 0, 0, 0, 0, 0, "R5");
    step(0, 0, 1, A, 4'h2, 0, 0, 0, "R6");
    step(1, A, 0, 0, 0, 0, 0, 0, "R6");
    step(0, 0, 0, A, 4'hF, 1, 4'h0, 0, "R10");
    step(1, A, 0, 0, 0, 0, 0, 0, "R10");
    step(0, A, 0, 0, 0, 0, 0, 0, "R9");
    step(0, 0, 1, B, 4'h1, 0, 0, 0, "R2");
    step(1, A, 0, 0, 0, 0, 0, 0, "R2");
    step(1, B, 0, 0, 0, 0, 0, 0, "R2");
    begin
      logic [31:0] pool [6] = '{A, B, C, 32'h0000_0300, 32'h0001_0104, 32'h0000_0008};
      logic [3:0] fv [3] = '{4'h4, 4'h6, 4'h9};
      void'($urandom(32'd1234));
      for (int n = 0; n < 4000; n++) begin
        logic [31:0] lp = pool[$urandom_range(0, 5)];
        logic [31:0] rp = pool[$urandom_range(0, 5)];
        step(1'($urandom_range(0, 1)), lp, 1'($urandom_range(0, 1)), rp,
             fv[$urandom_range(0, 2)], 1'($urandom_range(0, 1)), fv[$urandom_range(0, 2)],
             2'($urandom_range(0, 3)), "R4");
      end
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, "R7");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule